// File: doc/BRIEF.md
# Shared-Memory Mailbox Command Engine

This block is a byte-wide shared memory that a host processor reaches over a small memory-mapped request channel. Beyond storing bytes, it watches a handful of fixed byte positions. A write to the command-trigger byte of the mailbox page starts a short sequence. The sequencer echoes the command ID into the response slot and decodes the command code. For the record-update command it copies a run of bytes out of a staging page into the record area of the selected unit. It then writes a completion code back into the mailbox. A write to the response slot hands the ID back into the trigger slot. Writes to three per-CPU doorbell bytes send a one-cycle start request, carrying a fixed start address, to the matching secondary CPU when that CPU is present.

The byte index is the bus address shifted right by six, so every byte sits in its own 64-byte-aligned slot. The index space is 16 KB, but storage is sparse. The mailbox page 0x00xx, the doorbell page 0x34xx and the staging page 0x35xx are fully stored. Each legal unit page keeps only its first `2^REC_W` bytes. All other indices read as zero and drop writes.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as the sequencer runs, and the host must hold its request stable until it is taken. Read data returns on `rsp_valid` one cycle after the read is taken. The response channel has no back-pressure, so the host must take it in that cycle.

Top module: `mbx_engine`

## Requirements
- R1: The byte index is `req_addr[19:6]`; the low six address bits are ignored. A taken write stores `req_wdata`. A taken read returns the stored byte on `rsp_data`, with `rsp_valid` high for exactly the following cycle.
- R2: Stored bytes are these: indices 0x0000–0x00FF, 0x3400–0x35FF, and offsets below 32 in each legal unit page (pages 0x01–0x08, 0x21–0x2A, 0x31–0x33, 0x3B–0x3F). Any other index reads 0x00, and a write to it has no effect.
- R3: After reset `req_ready` is 1 and `busy`, `rsp_valid` and `start_req` are 0. A taken write to index 0xFF makes `busy` high and `req_ready` low from the next cycle until the completion code has been written.
- R4: After a write to 0xFF, byte 0xFD holds the command ID just written to 0xFF.
- R5: Command code 0x01 (byte 0xFE) with a legal unit qualifier (byte 0xFB) copies `[0xF9]+1` bytes. Byte i goes from index 0x3500+[0xFA]+i to index [0xFB]*0x100+[0xFA]+i. Byte 0xFC then receives 0x00.
- R6: Command 0x01 with a qualifier outside the legal unit pages copies nothing and writes 0x80 to 0xFC.
- R7: For qualifiers 0x21–0x24, command 0x01 copies only when (qualifier − 0x20) is at most `cpu_count`. Otherwise it copies nothing and writes 0x80 to 0xFC.
- R8: Command codes 0x02 and 0x03 write 0x00 to 0xFC. Any code other than 0x01–0x03 (0xF0 included) writes 0x81.
- R9: A taken write to 0xFD copies byte 0xFD into byte 0xFF, with `busy` high for exactly one cycle.
- R10: A taken write to index 0x3428, 0x3438 or 0x3448 raises `start_req` bit 0, 1 or 2 for one cycle in the cycle after the write. This happens only when `cpu_count` exceeds the CPU number (1, 2 or 3). At most one bit is high at a time.
- R11: The copy moves one byte per cycle. The host sees `req_ready` low for N+2 cycles for an N-byte copy and for 2 cycles for any other command.
- R12: `start_addr` always carries 0x8001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_count | input | 3 | Number of CPUs present (1–4) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request taken when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Bus address; byte index in bits 19:6 |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read data valid, one cycle after a taken read |
| rsp_data | output | 8 | Read data byte |
| busy | output | 1 | Sequencer running |
| start_req | output | 3 | One-cycle start request for CPUs 1..3 |
| start_addr | output | 16 | Start address given with start_req |

## Verification
The checker module watches the timing rules on every cycle. It checks that responses appear only after a taken read, that a trigger write always raises busy, and that the end-of-command write holds busy for a single cycle. It also checks that start requests are one-hot, follow a taken write and never target a missing CPU. The memory contents are left to the bench's scenarios. These cover the echoed ID, the copied bytes and where they land, the completion codes for each command and qualifier case, the CPU-count gate on qualifiers, the sparse backing, and the exact stall length of each sequence.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ECHO,
    SQ_COPY,
    SQ_POST,
    SQ_RETURN
  } seq_state_e;

  // mailbox byte positions (decoded by the host firmware, so fixed)
  localparam logic [7:0] MB_LEN    = 8'hF9;
  localparam logic [7:0] MB_OFF    = 8'hFA;
  localparam logic [7:0] MB_QUAL   = 8'hFB;
  localparam logic [7:0] MB_CODE   = 8'hFC;
  localparam logic [7:0] MB_RESP   = 8'hFD;
  localparam logic [7:0] MB_OPCODE = 8'hFE;
  localparam logic [7:0] MB_TRIG   = 8'hFF;

  localparam logic [7:0] OP_RECORD  = 8'h01;
  localparam logic [7:0] OP_BAUD    = 8'h02;
  localparam logic [7:0] OP_CONSOLE = 8'h03;

  localparam logic [7:0] CC_OK     = 8'h00;
  localparam logic [7:0] CC_ERR    = 8'h80;
  localparam logic [7:0] CC_BADCMD = 8'h81;

  localparam logic [7:0] PG_DOORBELL = 8'h34;
  localparam logic [7:0] PG_STAGE    = 8'h35;
  localparam int         N_UNIT      = 26;

  function automatic logic unit_ok(input logic [7:0] q);
    return (q >= 8'h01 && q <= 8'h08) || (q >= 8'h21 && q <= 8'h2A) ||
           (q >= 8'h31 && q <= 8'h33) || (q >= 8'h3B && q <= 8'h3F);
  endfunction

  // dense slot number of a legal unit page, 0..25
  function automatic logic [4:0] unit_slot(input logic [7:0] q);
    logic [7:0] s;
    if (q <= 8'h08)      s = q - 8'h01;
    else if (q <= 8'h2A) s = q - 8'h21 + 8'd8;
    else if (q <= 8'h33) s = q - 8'h31 + 8'd18;
    else                 s = q - 8'h3B + 8'd21;
    return s[4:0];
  endfunction

endpackage

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int REC_W = 5
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [7:0]       rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [7:0]       rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       tap_len,
  output logic [7:0]       tap_off,
  output logic [7:0]       tap_qual,
  output logic [7:0]       tap_opcode,
  output logic [7:0]       tap_trig,
  output logic [7:0]       tap_resp
);

  localparam int PAGE_B = 256;
  localparam int REC_B  = 1 << REC_W;
  localparam int DEPTH  = 3 * PAGE_B + N_UNIT * REC_B;
  localparam int PW     = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  // returns {stored, physical index}
  function automatic logic [PW:0] locate(input logic [IDX_W-1:0] i);
    logic [7:0] pg;
    logic [7:0] lo;
    pg = 8'(i[IDX_W-1:8]);
    lo = i[7:0];
    if (pg == 8'h00)
      return {1'b1, PW'(lo)};
    else if (pg == PG_DOORBELL)
      return {1'b1, PW'(PAGE_B) + PW'(lo)};
    else if (pg == PG_STAGE)
      return {1'b1, PW'(2 * PAGE_B) + PW'(lo)};
    else if (unit_ok(pg) && (9'(lo) < 9'(REC_B)))
      return {1'b1, PW'(3 * PAGE_B) + PW'(unit_slot(pg)) * PW'(REC_B) + PW'(lo)};
    else
      return '0;
  endfunction

  logic [PW:0] loc_a, loc_b, loc_w;

  always_comb begin
    loc_a = locate(rd_a_idx);
    loc_b = locate(rd_b_idx);
    loc_w = locate(wr_idx);
    rd_a_data = loc_a[PW] ? mem[loc_a[PW-1:0]] : 8'h00;
    rd_b_data = loc_b[PW] ? mem[loc_b[PW-1:0]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (wr_en && loc_w[PW]) mem[loc_w[PW-1:0]] <= wr_data;
  end

  assign tap_len    = mem[PW'(MB_LEN)];
  assign tap_off    = mem[PW'(MB_OFF)];
  assign tap_qual   = mem[PW'(MB_QUAL)];
  assign tap_opcode = mem[PW'(MB_OPCODE)];
  assign tap_trig   = mem[PW'(MB_TRIG)];
  assign tap_resp   = mem[PW'(MB_RESP)];

endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
  import mbx_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cpu_count,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  input  logic [7:0]       tap_len,
  input  logic [7:0]       tap_off,
  input  logic [7:0]       tap_qual,
  input  logic [7:0]       tap_opcode,
  input  logic [7:0]       tap_trig,
  input  logic [7:0]       tap_resp,
  output logic [IDX_W-1:0] copy_rd_idx,
  input  logic [7:0]       copy_rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             busy
);

  localparam logic [IDX_W-1:0] STAGE_BASE = IDX_W'({PG_STAGE, 8'h00});

  seq_state_e state_q;
  logic [7:0] len_q, off_q, qual_q, cnt_q, code_q;

  logic qual_pass;
  always_comb begin
    qual_pass = unit_ok(tap_qual);
    if (tap_qual >= 8'h21 && tap_qual <= 8'h24)
      qual_pass = (tap_qual - 8'h20) <= 8'(cpu_count);
  end

  logic [IDX_W-1:0] dst_idx;
  assign copy_rd_idx = STAGE_BASE + IDX_W'(off_q) + IDX_W'(cnt_q);
  assign dst_idx     = IDX_W'({qual_q, 8'h00}) + IDX_W'(off_q) + IDX_W'(cnt_q);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = host_idx;
    wr_data = host_wdata;
    unique case (state_q)
      SQ_IDLE:   wr_en = host_wr;
      SQ_ECHO:   begin wr_en = 1'b1; wr_idx = IDX_W'(MB_RESP); wr_data = tap_trig; end
      SQ_COPY:   begin wr_en = 1'b1; wr_idx = dst_idx;         wr_data = copy_rd_data; end
      SQ_POST:   begin wr_en = 1'b1; wr_idx = IDX_W'(MB_CODE); wr_data = code_q; end
      SQ_RETURN: begin wr_en = 1'b1; wr_idx = IDX_W'(MB_TRIG); wr_data = tap_resp; end
      default:   wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      len_q   <= '0;
      off_q   <= '0;
      qual_q  <= '0;
      cnt_q   <= '0;
      code_q  <= CC_OK;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (host_wr && host_idx == IDX_W'(MB_TRIG))      state_q <= SQ_ECHO;
          else if (host_wr && host_idx == IDX_W'(MB_RESP)) state_q <= SQ_RETURN;
        end
        SQ_ECHO: begin
          len_q  <= tap_len;
          off_q  <= tap_off;
          qual_q <= tap_qual;
          cnt_q  <= '0;
          if (tap_opcode == OP_RECORD) begin
            if (qual_pass) state_q <= SQ_COPY;
            else begin code_q <= CC_ERR; state_q <= SQ_POST; end
          end else if (tap_opcode == OP_BAUD || tap_opcode == OP_CONSOLE) begin
            code_q <= CC_OK; state_q <= SQ_POST;
          end else begin
            code_q <= CC_BADCMD; state_q <= SQ_POST;
          end
        end
        SQ_COPY: begin
          cnt_q <= cnt_q + 8'd1;
          if (cnt_q == len_q) begin
            code_q  <= CC_OK;
            state_q <= SQ_POST;
          end
        end
        SQ_POST:   state_q <= SQ_IDLE;
        SQ_RETURN: state_q <= SQ_IDLE;
        default:   state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state_q != SQ_IDLE);

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int IDX_W = 14,
  parameter int CNT_W = 3,
  parameter int N_SEC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cpu_count,
  input  logic             host_wr,
  input  logic [IDX_W-1:0] host_idx,
  output logic [N_SEC-1:0] start_req
);

  localparam int BELL_BASE = 32'h3418;
  localparam int BELL_STEP = 16;

  for (genvar k = 0; k < N_SEC; k++) begin : g_bell
    localparam logic [IDX_W-1:0] BELL_IDX = IDX_W'(BELL_BASE + BELL_STEP * (k + 1));
    always_ff @(posedge clk) begin
      if (!rst_n) start_req[k] <= 1'b0;
      else start_req[k] <= host_wr && (host_idx == BELL_IDX) &&
                           (int'(cpu_count) > k + 1);
    end
  end

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine #(
  parameter int          IDX_W    = 14,
  parameter int          REC_W    = 5,
  parameter int          CNT_W    = 3,
  parameter int          N_SEC    = 3,
  parameter logic [15:0] START_PC = 16'h8001,
  localparam int         ADDR_W   = IDX_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cpu_count,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy,
  output logic [N_SEC-1:0]  start_req,
  output logic [15:0]       start_addr
);

  logic [IDX_W-1:0] host_idx;
  logic             take, host_wr;
  logic             unused_slot_bits;

  assign host_idx         = req_addr[ADDR_W-1:6];
  assign unused_slot_bits = ^req_addr[5:0];
  assign req_ready        = ~busy;
  assign take             = req_valid & req_ready;
  assign host_wr          = take & req_write;
  assign start_addr       = START_PC;

  logic [7:0]       rd_a_data, rd_b_data;
  logic [IDX_W-1:0] copy_rd_idx, wr_idx;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       tap_len, tap_off, tap_qual, tap_opcode, tap_trig, tap_resp;

  mbx_store #(.IDX_W(IDX_W), .REC_W(REC_W)) u_store (
    .clk(clk),
    .rd_a_idx(host_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(copy_rd_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .tap_len(tap_len), .tap_off(tap_off), .tap_qual(tap_qual),
    .tap_opcode(tap_opcode), .tap_trig(tap_trig), .tap_resp(tap_resp)
  );

  mbx_sequencer #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
    .host_wr(host_wr), .host_idx(host_idx), .host_wdata(req_wdata),
    .tap_len(tap_len), .tap_off(tap_off), .tap_qual(tap_qual),
    .tap_opcode(tap_opcode), .tap_trig(tap_trig), .tap_resp(tap_resp),
    .copy_rd_idx(copy_rd_idx), .copy_rd_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy)
  );

  mbx_doorbell #(.IDX_W(IDX_W), .CNT_W(CNT_W), .N_SEC(N_SEC)) u_bell (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
    .host_wr(host_wr), .host_idx(host_idx), .start_req(start_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= take & ~req_write;
      if (take & ~req_write) rsp_data <= rd_a_data;
    end
  end

endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 3,
  parameter int N_SEC  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cpu_count,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              busy,
  input logic [N_SEC-1:0]  start_req
);

  logic wr_take, rd_take;
  assign wr_take = req_valid && req_ready && req_write;
  assign rd_take = req_valid && req_ready && !req_write;

  // R1
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_take));

  // R3
  trigger_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && req_addr[ADDR_W-1:6] == (ADDR_W-6)'(8'hFF)) |=> busy);

  // R9
  return_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && req_addr[ADDR_W-1:6] == (ADDR_W-6)'(8'hFD)) |=> busy ##1 !busy);

  // R10
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_req));

  // R10
  start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req != '0) |-> $past(wr_take));

  for (genvar k = 0; k < N_SEC; k++) begin : g_exist
    // R10
    start_cpu_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[k] |-> (int'($past(cpu_count)) > k + 1));
  end

endmodule

bind mbx_engine mbx_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_SEC(N_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .busy(busy), .start_req(start_req)
);

// File: tb/sim_mbx_engine.sv
`timescale 1ns/1ps
module sim_mbx_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu_count = 3'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        busy;
  logic [2:0]  start_req;
  logic [15:0] start_addr;

  always #4 clk = ~clk;

  mbx_engine u0 (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
    .start_req(start_req), .start_addr(start_addr)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as responses arrive
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) check("R1 unexpected response", 1, 0);
        else check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [13:0] idx, input logic [7:0] d,
                           output int stall, output logic [2:0] sr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = {idx, 6'h00}; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    sr = start_req;
    stall = 0;
    while (!req_ready) begin stall++; @(negedge clk); end
  endtask

  task automatic wr(input logic [13:0] idx, input logic [7:0] d);
    int s; logic [2:0] r;
    bus_write(idx, d, s, r);
  endtask

  task automatic rd(input logic [13:0] idx, input logic [5:0] low,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {idx, low};
    @(posedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    check("R1 responses outstanding", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int st; logic [2:0] sr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 ready after reset", req_ready, 1);
    check("R3 busy after reset", busy, 0);
    check("R3 rsp_valid after reset", rsp_valid, 0);
    check("R3 start_req after reset", start_req, 0);
    check("R12 start address", start_addr, 16'h8001);

    // R1 slot addressing
    wr(14'h0010, 8'hA5);
    rd(14'h0010, 6'h00, 8'hA5, "R1 read back");
    rd(14'h0010, 6'h3F, 8'hA5, "R1 low bits ignored");

    // R2 sparse backing
    wr(14'h1000, 8'h77);
    rd(14'h1000, 6'h00, 8'h00, "R2 unbacked page");
    wr(14'h0140, 8'h66);
    rd(14'h0140, 6'h00, 8'h00, "R2 record offset beyond window");
    wr(14'h0105, 8'h44);
    rd(14'h0105, 6'h00, 8'h44, "R2 record window stored");

    // R5 record copy of four bytes
    wr(14'h3504, 8'h10); wr(14'h3505, 8'h21);
    wr(14'h3506, 8'h32); wr(14'h3507, 8'h43);
    wr(14'h00F9, 8'h03); wr(14'h00FA, 8'h04);
    wr(14'h00FB, 8'h02); wr(14'h00FE, 8'h01);
    bus_write(14'h00FF, 8'h5A, st, sr);
    check("R11 copy stall cycles", st, 6);
    rd(14'h00FD, 6'h00, 8'h5A, "R4 id echoed");
    rd(14'h00FC, 6'h00, 8'h00, "R5 completion ok");
    rd(14'h0204, 6'h00, 8'h10, "R5 dest byte 0");
    rd(14'h0205, 6'h00, 8'h21, "R5 dest byte 1");
    rd(14'h0206, 6'h00, 8'h32, "R5 dest byte 2");
    rd(14'h0207, 6'h00, 8'h43, "R5 dest byte 3");

    // R6 illegal qualifier
    wr(14'h00FB, 8'h10);
    bus_write(14'h00FF, 8'h61, st, sr);
    check("R11 rejected command stall", st, 2);
    rd(14'h00FC, 6'h00, 8'h80, "R6 illegal qualifier code");
    rd(14'h00FD, 6'h00, 8'h61, "R4 id echoed on error");

    // R7 CPU qualifier gated by cpu_count (=2)
    wr(14'h2300, 8'h11); wr(14'h2200, 8'h11);
    wr(14'h3500, 8'h99);
    wr(14'h00F9, 8'h00); wr(14'h00FA, 8'h00);
    wr(14'h00FB, 8'h23);
    wr(14'h00FF, 8'h62);
    rd(14'h00FC, 6'h00, 8'h80, "R7 absent CPU code");
    rd(14'h2300, 6'h00, 8'h11, "R7 absent CPU record untouched");
    wr(14'h00FB, 8'h22);
    bus_write(14'h00FF, 8'h63, st, sr);
    check("R11 single byte copy stall", st, 3);
    rd(14'h00FC, 6'h00, 8'h00, "R7 present CPU code");
    rd(14'h2200, 6'h00, 8'h99, "R7 present CPU record copied");

    // R8 other command codes
    wr(14'h00FE, 8'h02);
    bus_write(14'h00FF, 8'h70, st, sr);
    check("R11 baud stall", st, 2);
    rd(14'h00FC, 6'h00, 8'h00, "R8 baud code");
    wr(14'h00FE, 8'h07);
    wr(14'h00FF, 8'h71);
    rd(14'h00FC, 6'h00, 8'h81, "R8 unknown code");
    wr(14'h00FE, 8'h03);
    wr(14'h00FF, 8'h72);
    rd(14'h00FC, 6'h00, 8'h00, "R8 console code");
    wr(14'h00FE, 8'hF0);
    wr(14'h00FF, 8'h73);
    rd(14'h00FC, 6'h00, 8'h81, "R8 code F0 unknown");

    // R9 end of command
    bus_write(14'h00FD, 8'h33, st, sr);
    check("R9 return stall", st, 1);
    rd(14'h00FF, 6'h00, 8'h33, "R9 id handed back");

    // R10 doorbells
    bus_write(14'h3428, 8'h01, st, sr);
    check("R10 CPU1 start", sr, 3'b001);
    bus_write(14'h3438, 8'h01, st, sr);
    check("R10 CPU2 absent", sr, 3'b000);
    cpu_count = 3'd4;
    bus_write(14'h3448, 8'h5C, st, sr);
    check("R10 CPU3 start", sr, 3'b100);
    @(negedge clk);
    check("R10 pulse one cycle", start_req, 3'b000);
    rd(14'h3448, 6'h00, 8'h5C, "R2 doorbell byte stored");

    finish_run();
  end

endmodule